// File: doc/BRIEF.md
# Pulse-Duration Sequence Transmitter

This block plays out a serial waveform that the host describes as a list of timed levels. Each entry pairs an output level with a duration. Durations are counted in ticks of a divided clock. Entries sit two to a 32-bit word in a local item memory. The host fills that memory through a write port, raises `run`, and the block walks the words in order, driving each level for its duration. A zero duration marks the end of the frame.

The host can also:
- gate the output with a square-wave carrier while it sits at a chosen level;
- choose what the pin shows between frames;
- replay the frame continuously;
- let the read pointer wrap around the allocated memory so the frame can run without end.

A threshold event reports each time a programmed number of words has been consumed, so that the host can refill the part already sent.

The host write port uses valid/ready. `wr_ready` is held high, so every beat with `wr_valid` high is accepted on that clock edge. There is no back-pressure. A word written at edge N is seen by any fetch made after edge N. Configuration, `run` and `rewind` are plain levels. `end_evt` and `thr_evt` are single-cycle pulses.

Top module: `pdseq_tx`

## Requirements
- R1: Each memory word holds two entries. The first entry has its duration in bits [14:0] and its level in bit 15. The second entry has its duration in bits [30:16] and its level in bit 31. The first entry is sent before the second.
- R2: A nonzero entry drives its level on `tx_out` for exactly duration × `cfg_div` clock cycles, with no gap before the next entry of the same pass.
- R3: An entry with duration zero ends the frame. `end_evt` pulses for one cycle, in the first cycle after the last level, and `tx_oe`/`tx_out` return to their idle behaviour in that same cycle.
- R4: While no frame level is being driven, `tx_oe` equals `cfg_idle_en`, and `tx_out` shows `cfg_idle_level` when that is enabled (0 otherwise).
- R5: With `cfg_car_en` set and the entry level equal to `cfg_car_level`, `tx_out` follows a carrier. The carrier is high for `cfg_car_high` clocks and then low for `cfg_car_low` clocks, repeating, and it restarts high at the first cycle of each entry.
- R6: The carrier leaves `tx_out` at the plain level when the entry level differs from `cfg_car_level`, or when `cfg_car_en` is clear.
- R7: With `cfg_loop` set, an end entry pulses `end_evt` and the frame restarts from word 0, keeping `tx_oe` high between passes.
- R8: The allocated memory is `cfg_blocks` × 64 words. With `cfg_wrap` set, the pointer returns to word 0 after the last allocated word. With it clear, passing the last word ends the frame as an end entry would.
- R9: `thr_evt` pulses once each time `cfg_thresh` further words have been fully consumed since the start. A threshold of 0 produces no pulses.
- R10: Clearing `run` stops the frame at the next entry boundary, leaving the pointer on the first unsent entry. A rising `run` with `rewind` clear resumes from there. A rising `run` with `rewind` set starts from the first entry of word 0.
- R11: `wr_ready` is always high, and a written word replaces the stored one for all later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | 9 | Word address of the write |
| wr_data | input | 32 | Word holding two entries |
| cfg_div | input | 8 | Tick divider in source clocks (nonzero) |
| cfg_blocks | input | 4 | Allocated 64-word blocks, 1 to 8 |
| cfg_loop | input | 1 | Restart the frame at the end entry |
| cfg_wrap | input | 1 | Wrap the pointer at the end of the allocation |
| cfg_thresh | input | 8 | Words per threshold event, 0 disables |
| cfg_car_en | input | 1 | Carrier gating enable |
| cfg_car_level | input | 1 | Entry level that carries the carrier |
| cfg_car_high | input | 16 | Carrier high time in clocks |
| cfg_car_low | input | 16 | Carrier low time in clocks |
| cfg_idle_en | input | 1 | Drive the pin between frames |
| cfg_idle_level | input | 1 | Level driven between frames |
| run | input | 1 | Rising edge starts; low stops at the next boundary |
| rewind | input | 1 | Start from word 0 on the rising edge of run |
| tx_out | output | 1 | Serial output level |
| tx_oe | output | 1 | Output drive enable |
| end_evt | output | 1 | Frame-end pulse |
| thr_evt | output | 1 | Threshold pulse |

## Verification
The embedded assertions watch properties that must hold on every cycle:
- end events are single-cycle pulses;
- the frame only ever goes inactive at an entry boundary;
- the tick never fires on two consecutive cycles unless the divider is one;
- the read pointer never passes one beyond the largest allocation;
- threshold pulses never occur with a zero threshold.

The exact duration of each level, the carrier pattern, resuming after a stop, rewinding, looping, wrapping and the number of threshold pulses per frame are sequence properties that only the bench's frame scenarios can show.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  localparam int DUR_W  = 15;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } pd_entry_t;

  typedef struct packed {
    pd_entry_t hi;  // sent second
    pd_entry_t lo;  // sent first
  } pd_word_t;
endpackage

// File: rtl/pdseq_tick_gen.sv
module pdseq_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = div_i - 1'b1;
  assign tick_o = (cnt_q == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || div_i == DIV_W'(1)));
endmodule

// File: rtl/pdseq_carrier.sv
module pdseq_carrier #(
  parameter int CAR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CAR_W-1:0] high_i,
  input  logic [CAR_W-1:0] low_i,
  output logic             wave_o
);
  logic             ph_q;
  logic [CAR_W-1:0] cnt_q;
  logic [CAR_W-1:0] cnt_inc;
  logic [CAR_W-1:0] span;

  assign cnt_inc = cnt_q + 1'b1;
  assign span    = ph_q ? high_i : low_i;
  assign wave_o  = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (clear_i) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_inc >= span) begin
      ph_q  <= ~ph_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  // R5
  car_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> wave_o);
endmodule

// File: rtl/pdseq_item_mem.sv
module pdseq_item_mem #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9
) (
  input  logic                          clk,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [pdseq_pkg::WORD_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output pdseq_pkg::pd_word_t           rd_word_o
);
  logic [pdseq_pkg::WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_word_o = pdseq_pkg::pd_word_t'(mem_q[rd_addr_i]);
endmodule

// File: rtl/pdseq_seq.sv
module pdseq_seq
  import pdseq_pkg::*;
#(
  parameter int BLK_WORDS = 64,
  parameter int MAX_BLK   = 8,
  parameter int THR_W     = 8,
  parameter int ADDR_W    = 9,
  parameter int PTR_W     = 10,
  parameter int BLK_SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 rewind_i,
  input  logic                 loop_i,
  input  logic                 wrap_i,
  input  logic [BLK_SEL_W-1:0] blocks_i,
  input  logic [THR_W-1:0]     thresh_i,
  input  logic                 tick_i,
  input  pd_word_t             word_i,
  output logic [ADDR_W-1:0]    rd_addr_o,
  output logic                 load_o,
  output logic                 lvl_valid_o,
  output logic                 level_o,
  output logic                 end_evt_o,
  output logic                 thr_evt_o
);
  localparam int MEM_WORDS = MAX_BLK * BLK_WORDS;

  logic                 run_q, active_q, pend_q, half_q, lvl_valid_q, level_q;
  logic [PTR_W-1:0]     ptr_q;
  logic [DUR_W-1:0]     dur_q;
  logic [THR_W-1:0]     wcnt_q;
  logic [BLK_SEL_W-1:0] blk_eff;
  logic [PTR_W-1:0]     last_ptr;
  logic [THR_W-1:0]     wcnt_inc;
  pd_entry_t            cur;
  logic                 start_req, past_end, is_end, load;

  always_comb begin
    if (blocks_i == '0)                            blk_eff = BLK_SEL_W'(1);
    else if (blocks_i > BLK_SEL_W'(MAX_BLK))       blk_eff = BLK_SEL_W'(MAX_BLK);
    else                                           blk_eff = blocks_i;
  end

  assign last_ptr  = PTR_W'(int'(blk_eff) * BLK_WORDS - 1);
  assign past_end  = ptr_q > last_ptr;
  assign rd_addr_o = ptr_q[ADDR_W-1:0];
  assign cur       = half_q ? word_i.hi : word_i.lo;
  assign is_end    = past_end || (cur.dur == '0);
  assign start_req = run_i && !run_q && !active_q;
  assign load      = active_q && (pend_q || (tick_i && dur_q == DUR_W'(1)));
  assign wcnt_inc  = wcnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      half_q      <= 1'b0;
      lvl_valid_q <= 1'b0;
      level_q     <= 1'b0;
      ptr_q       <= '0;
      dur_q       <= '0;
      wcnt_q      <= '0;
      end_evt_o   <= 1'b0;
      thr_evt_o   <= 1'b0;
    end else begin
      run_q     <= run_i;
      end_evt_o <= 1'b0;
      thr_evt_o <= 1'b0;
      if (start_req) begin
        active_q    <= 1'b1;
        pend_q      <= 1'b1;
        lvl_valid_q <= 1'b0;
        wcnt_q      <= '0;
        if (rewind_i) begin
          ptr_q  <= '0;
          half_q <= 1'b0;
        end
      end else if (load) begin
        pend_q <= 1'b0;
        if (!run_i) begin
          active_q    <= 1'b0;
          lvl_valid_q <= 1'b0;
        end else if (is_end) begin
          end_evt_o <= 1'b1;
          if (loop_i) begin
            ptr_q  <= '0;
            half_q <= 1'b0;
            pend_q <= 1'b1;
            wcnt_q <= '0;
          end else begin
            active_q    <= 1'b0;
            lvl_valid_q <= 1'b0;
          end
        end else begin
          dur_q       <= cur.dur;
          level_q     <= cur.lvl;
          lvl_valid_q <= 1'b1;
          half_q      <= ~half_q;
          if (half_q) begin
            if (ptr_q == last_ptr && wrap_i) ptr_q <= '0;
            else                             ptr_q <= ptr_q + 1'b1;
            if (thresh_i != '0 && wcnt_inc == thresh_i) begin
              thr_evt_o <= 1'b1;
              wcnt_q    <= '0;
            end else begin
              wcnt_q <= wcnt_inc;
            end
          end
        end
      end else if (active_q && tick_i) begin
        dur_q <= dur_q - 1'b1;
      end
    end
  end

  assign load_o      = load;
  assign lvl_valid_o = lvl_valid_q;
  assign level_o     = level_q;

  // R3
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt_o |=> !end_evt_o);

  // R10
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(load));

  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(MEM_WORDS));

  // R9
  thr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt_o |-> $past(thresh_i) != '0);
endmodule

// File: rtl/pdseq_tx.sv
module pdseq_tx #(
  parameter int BLK_WORDS = 64,
  parameter int MAX_BLK   = 8,
  parameter int DIV_W     = 8,
  parameter int CAR_W     = 16,
  parameter int THR_W     = 8,
  localparam int MEM_WORDS = BLK_WORDS * MAX_BLK,
  localparam int ADDR_W    = $clog2(MEM_WORDS),
  localparam int PTR_W     = ADDR_W + 1,
  localparam int BLK_SEL_W = $clog2(MAX_BLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [BLK_SEL_W-1:0] cfg_blocks,
  input  logic                 cfg_loop,
  input  logic                 cfg_wrap,
  input  logic [THR_W-1:0]     cfg_thresh,
  input  logic                 cfg_car_en,
  input  logic                 cfg_car_level,
  input  logic [CAR_W-1:0]     cfg_car_high,
  input  logic [CAR_W-1:0]     cfg_car_low,
  input  logic                 cfg_idle_en,
  input  logic                 cfg_idle_level,
  input  logic                 run,
  input  logic                 rewind,
  output logic                 tx_out,
  output logic                 tx_oe,
  output logic                 end_evt,
  output logic                 thr_evt
);
  pdseq_pkg::pd_word_t rd_word;
  logic [ADDR_W-1:0]   rd_addr;
  logic                load, tick, car_wave, lvl_valid, level, mod_on;

  assign wr_ready = 1'b1;

  pdseq_item_mem #(.DEPTH(MEM_WORDS), .ADDR_W(ADDR_W)) u_mem (
    .clk       (clk),
    .wr_en_i   (wr_valid),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_word_o (rd_word)
  );

  pdseq_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .div_i   (cfg_div),
    .tick_o  (tick)
  );

  pdseq_carrier #(.CAR_W(CAR_W)) u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .high_i  (cfg_car_high),
    .low_i   (cfg_car_low),
    .wave_o  (car_wave)
  );

  pdseq_seq #(
    .BLK_WORDS (BLK_WORDS),
    .MAX_BLK   (MAX_BLK),
    .THR_W     (THR_W),
    .ADDR_W    (ADDR_W),
    .PTR_W     (PTR_W),
    .BLK_SEL_W (BLK_SEL_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .rewind_i    (rewind),
    .loop_i      (cfg_loop),
    .wrap_i      (cfg_wrap),
    .blocks_i    (cfg_blocks),
    .thresh_i    (cfg_thresh),
    .tick_i      (tick),
    .word_i      (rd_word),
    .rd_addr_o   (rd_addr),
    .load_o      (load),
    .lvl_valid_o (lvl_valid),
    .level_o     (level),
    .end_evt_o   (end_evt),
    .thr_evt_o   (thr_evt)
  );

  assign mod_on = cfg_car_en && (level == cfg_car_level);
  assign tx_out = lvl_valid ? (mod_on ? car_wave : level)
                            : (cfg_idle_en & cfg_idle_level);
  assign tx_oe  = lvl_valid | cfg_idle_en;

  // R4
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_oe) |-> (!tx_out && !lvl_valid));
endmodule

// File: tb/pdseq_tx_test.sv
`timescale 1ns/1ps
module pdseq_tx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  cfg_div;
  logic [3:0]  cfg_blocks;
  logic        cfg_loop, cfg_wrap;
  logic [7:0]  cfg_thresh;
  logic        cfg_car_en, cfg_car_level;
  logic [15:0] cfg_car_high, cfg_car_low;
  logic        cfg_idle_en, cfg_idle_level;
  logic        run, rewind;
  logic        tx_out, tx_oe, end_evt, thr_evt;

  int total = 0;
  int bad   = 0;
  logic tr [0:511];
  int ntr, n_end, n_thr;

  always #2.5 clk = ~clk;

  pdseq_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg_div(cfg_div),
    .cfg_blocks(cfg_blocks), .cfg_loop(cfg_loop), .cfg_wrap(cfg_wrap),
    .cfg_thresh(cfg_thresh), .cfg_car_en(cfg_car_en),
    .cfg_car_level(cfg_car_level), .cfg_car_high(cfg_car_high),
    .cfg_car_low(cfg_car_low), .cfg_idle_en(cfg_idle_en),
    .cfg_idle_level(cfg_idle_level), .run(run), .rewind(rewind),
    .tx_out(tx_out), .tx_oe(tx_oe), .end_evt(end_evt), .thr_evt(thr_evt)
  );

  // columns: divider, dur0, lvl0, dur1, lvl1
  localparam int NVEC = 4;
  localparam int VEC [NVEC][5] = '{
    '{1, 5, 1, 3, 0},
    '{3, 2, 0, 4, 1},
    '{2, 7, 1, 1, 0},
    '{4, 1, 1, 2, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input int d0, input int l0, input int d1, input int l1);
    return {1'(l1), 15'(d1), 1'(l0), 15'(d0)};
  endfunction

  task automatic put(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 9'(addr);
    wr_data  = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic frame(input logic rw, input int drop_at, input int maxc);
    bit seen = 0;
    ntr = 0; n_end = 0; n_thr = 0;
    @(negedge clk);
    rewind = rw;
    run    = 1'b1;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (end_evt) n_end++;
      if (thr_evt) n_thr++;
      if (tx_oe) begin
        seen = 1;
        if (ntr < 512) tr[ntr] = tx_out;
        ntr++;
      end else if (seen) begin
        break;
      end
      if (drop_at > 0 && c == drop_at) run = 1'b0;
    end
    run = 1'b0;
    @(negedge clk);
  endtask

  function automatic int mism(input int n0, input int l0, input int l1);
    int m = 0;
    for (int i = 0; i < ntr && i < 512; i++)
      if (int'(tr[i]) != ((i < n0) ? l0 : l1)) m++;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    cfg_div = 8'd1; cfg_blocks = 4'd1; cfg_loop = 1'b0; cfg_wrap = 1'b0;
    cfg_thresh = 8'd0; cfg_car_en = 1'b0; cfg_car_level = 1'b1;
    cfg_car_high = 16'd2; cfg_car_low = 16'd3; cfg_idle_en = 1'b0;
    cfg_idle_level = 1'b0; run = 1'b0; rewind = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R4 reset oe", int'(tx_oe), 0);
    chk("R4 reset out", int'(tx_out), 0);
    chk("R3 reset end_evt", int'(end_evt), 0);
    chk("R9 reset thr_evt", int'(thr_evt), 0);
    chk("R11 wr_ready", int'(wr_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R11: table of single-word frames
    for (int v = 0; v < NVEC; v++) begin
      cfg_div = 8'(VEC[v][0]);
      put(0, mkw(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]));
      put(1, 32'h0);
      frame(1'b1, 0, 200);
      chk("R2 frame length", ntr, (VEC[v][1] + VEC[v][3]) * VEC[v][0]);
      chk("R1 entry order/levels", mism(VEC[v][1] * VEC[v][0], VEC[v][2], VEC[v][4]), 0);
      chk("R3 single end event", n_end, 1);
    end

    // R3: zero first duration ends immediately
    put(0, mkw(0, 1, 5, 1));
    frame(1'b1, 0, 20);
    chk("R3 empty frame length", ntr, 0);
    chk("R3 empty frame end", n_end, 1);

    // R4: idle drive
    cfg_idle_en = 1'b1; cfg_idle_level = 1'b1;
    @(negedge clk);
    chk("R4 idle oe", int'(tx_oe), 1);
    chk("R4 idle high", int'(tx_out), 1);
    cfg_idle_level = 1'b0;
    @(negedge clk);
    chk("R4 idle low", int'(tx_out), 0);
    cfg_idle_en = 1'b0;

    // R5 R6: carrier on level 1, not on level 0
    cfg_div = 8'd1; cfg_car_en = 1'b1;
    put(0, mkw(10, 1, 6, 0));
    put(1, 32'h0);
    frame(1'b1, 0, 100);
    begin
      int m = 0;
      for (int i = 0; i < 10; i++) if (int'(tr[i]) != (((i % 5) < 2) ? 1 : 0)) m++;
      chk("R5 carrier pattern", m, 0);
      m = 0;
      for (int i = 10; i < 16; i++) if (tr[i] != 1'b0) m++;
      chk("R6 no carrier on other level", m, 0);
    end
    chk("R5 carrier frame length", ntr, 16);
    cfg_car_en = 1'b0;
    frame(1'b1, 0, 100);
    chk("R6 carrier disabled", mism(10, 1, 0), 0);

    // R10: stop, resume, rewind
    put(0, mkw(4, 1, 4, 0));
    put(1, mkw(6, 1, 0, 0));
    frame(1'b1, 2, 100);
    chk("R10 stop at boundary length", ntr, 4);
    chk("R10 stop level", mism(4, 1, 1), 0);
    frame(1'b0, 0, 100);
    chk("R10 resume length", ntr, 10);
    chk("R10 resume content", mism(4, 0, 1), 0);
    frame(1'b1, 0, 100);
    chk("R10 rewind length", ntr, 14);

    // R7: loop mode
    put(0, mkw(3, 1, 3, 0));
    put(1, 32'h0);
    cfg_loop = 1'b1;
    frame(1'b1, 40, 200);
    chk("R7 repeated ends", (n_end >= 3) ? 1 : 0, 1);
    chk("R7 output held through passes", (ntr >= 40 && ntr <= 48) ? 1 : 0, 1);
    cfg_loop = 1'b0;

    // R8 R9: full 64-word block
    for (int w = 0; w < 64; w++) put(w, mkw(1, 1, 1, 0));
    cfg_thresh = 8'd16;
    frame(1'b1, 0, 400);
    chk("R8 no-wrap length", ntr, 128);
    chk("R8 no-wrap end", n_end, 1);
    chk("R9 threshold count", n_thr, 4);
    cfg_thresh = 8'd0;
    frame(1'b1, 0, 400);
    chk("R9 threshold disabled", n_thr, 0);
    cfg_wrap = 1'b1; cfg_thresh = 8'd32;
    frame(1'b1, 200, 400);
    chk("R8 wrap continues", (ntr > 128) ? 1 : 0, 1);
    chk("R8 wrap no end", n_end, 0);
    chk("R9 threshold with wrap", n_thr, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule